// File: doc/BRIEF.md
# Backward-Pass Weight Read-Address Sequencer

This block produces the read-address stream that the backward pass of a multiplexed-neuron learning engine uses to fetch weights. The weights sit in K parallel memories laid out for forward access. Reading them for the backward pass without two requests landing on the same memory in one cycle needs a diagonal walk: one lane per cycle, K lanes per row, then a jump to the next row block. The memories themselves and the reordering of the returned words are handled elsewhere.

A one-cycle start pulse, given while the block is idle, captures a layer base address and the number of units active in the current stage. The block then presents one registered address per cycle until the row offset has passed the row limit. It signals the final address with a one-cycle done pulse. The stride between rows (M_IN+1), the row limit N_LIM and the lane count K_NCU are elaboration parameters.

Top module: `bwa_addr_gen`

## Requirements
- R1: While and after reset, with no start given, rd_addr is 0 and addr_valid, busy and done are 0.
- R2: A start pulse sampled while busy is 0 captures layer_base and active_num. busy is 1 from the next cycle. addr_valid is 1 from the cycle after that, through the final address. Changes to layer_base and active_num after the start edge do not alter the stream.
- R3: A lane counter steps 0,1,..,K_NCU-1 once per cycle while busy. The address for lane c in row block r is layer_base + r*(M_IN+1) + min(c, active_num). It appears on rd_addr one cycle after that lane state.
- R4: The row offset starts at 0. It grows by M_IN+1 each time the lane counter wraps from K_NCU-1, as long as the offset before the wrap is below N_LIM.
- R5: When the lane counter is at K_NCU-1 and the row offset is at least N_LIM, the sequence ends. Exactly ROWS*K_NCU addresses are produced, where ROWS = ceil(N_LIM/(M_IN+1)) + 1.
- R6: done is 1 for exactly the one cycle that presents the final address, and busy is 0 in that cycle. In the cycle after it, addr_valid, done and busy are all 0.
- R7: A start pulse that arrives while busy is 1 is ignored. The running address stream and its length stay unchanged.
- R8: When active_num is below K_NCU, lanes at or above active_num repeat the address of lane active_num. When active_num is K_NCU or more, no clamping occurs.
- R9: The sequence is correct when K_NCU exceeds N_LIM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, honoured only while idle |
| layer_base | input | AW | Base address of the current layer, captured at start |
| active_num | input | AW | Active units in the stage, captured at start |
| rd_addr | output | AW | Registered weight read address |
| addr_valid | output | 1 | rd_addr carries a sequence address |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle marker on the final address |

## Verification
The bench builds three copies of the block side by side. The first uses (M_IN,N_LIM,K_NCU) = (3,8,4), giving three row blocks of four lanes. The second uses (1,2,5), where the lane count exceeds the row limit. The third uses (4,9,3), where the stride does not divide the limit evenly. Across them, active counts of zero, below K_NCU, equal to it and above it reach both sides of the clamp, and the differing ROWS values exercise the row-limit compare at its edges. A start pulse during a run and inputs changed after the start edge show that the captured values govern the stream.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    // Per-cycle step decision taken at the lane counter's last lane.
    typedef struct packed {
        logic wrap;    // advance to the next row block
        logic finish;  // last row block complete, sequence ends
    } bwa_step_t;

    function automatic int lane_width(input int k);
        return (k > 1) ? $clog2(k) : 1;
    endfunction

    // Number of row blocks visited: offsets 0, s, 2s, ... up to the first >= n.
    function automatic int rows_needed(input int m, input int n);
        return ((n + m) / (m + 1)) + 1;
    endfunction

endpackage

// File: rtl/bwa_lane_counter.sv
module bwa_lane_counter #(
    parameter int K_NCU = 4,
    localparam int LW = bwa_pkg::lane_width(K_NCU)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [LW-1:0] lane,
    output logic          lane_last
);
    localparam logic [LW-1:0] LAST = LW'(K_NCU - 1);

    assign lane_last = (lane == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            lane <= '0;
        end else if (en) begin
            lane <= lane_last ? '0 : lane + 1'b1;
        end
    end
endmodule

// File: rtl/bwa_offset_tracker.sv
module bwa_offset_tracker
    import bwa_pkg::*;
#(
    parameter int M_IN  = 3,
    parameter int N_LIM = 8,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          lane_last,
    output logic [AW-1:0] offset,
    output bwa_step_t     step
);
    localparam logic [AW-1:0] STRIDE = AW'(M_IN + 1);
    localparam logic [AW-1:0] LIMIT  = AW'(N_LIM);

    always_comb begin
        step.finish = en && lane_last && (offset >= LIMIT);
        step.wrap   = en && lane_last && (offset <  LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst || step.finish) begin
            offset <= '0;
        end else if (step.wrap) begin
            offset <= offset + STRIDE;
        end
    end
endmodule

// File: rtl/bwa_addr_stage.sv
module bwa_addr_stage #(
    parameter int K_NCU = 4,
    parameter int AW    = 8,
    localparam int LW = bwa_pkg::lane_width(K_NCU)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          finish,
    input  logic [LW-1:0] lane,
    input  logic [AW-1:0] offset,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] act,
    output logic [AW-1:0] rd_addr,
    output logic          addr_valid,
    output logic          done
);
    logic [AW-1:0] lane_ext;
    logic [AW-1:0] lane_eff;
    logic [AW-1:0] addr_next;

    always_comb begin
        lane_ext  = AW'(lane);
        lane_eff  = (lane_ext < act) ? lane_ext : act;
        addr_next = offset + lane_eff + base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_addr    <= '0;
            addr_valid <= 1'b0;
            done       <= 1'b0;
        end else begin
            addr_valid <= en;
            done       <= finish;
            if (en) begin
                rd_addr <= addr_next;
            end
        end
    end
endmodule

// File: rtl/bwa_addr_gen.sv
module bwa_addr_gen
    import bwa_pkg::*;
#(
    parameter int M_IN  = 3,
    parameter int N_LIM = 8,
    parameter int K_NCU = 4,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] layer_base,
    input  logic [AW-1:0] active_num,
    output logic [AW-1:0] rd_addr,
    output logic          addr_valid,
    output logic          busy,
    output logic          done
);
    localparam int LW = lane_width(K_NCU);

    logic          en_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] act_q;
    logic [LW-1:0] lane;
    logic          lane_last;
    logic [AW-1:0] offset;
    bwa_step_t     step;

    // Run control: start is taken only when idle (R2, R7); finish ends it (R5).
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            base_q <= '0;
            act_q  <= '0;
        end else if (!en_q && start) begin
            en_q   <= 1'b1;
            base_q <= layer_base;
            act_q  <= active_num;
        end else if (step.finish) begin
            en_q   <= 1'b0;
        end
    end

    assign busy = en_q;

    bwa_lane_counter #(.K_NCU(K_NCU)) u_lane (
        .clk       (clk),
        .rst       (rst),
        .en        (en_q),
        .lane      (lane),
        .lane_last (lane_last)
    );

    bwa_offset_tracker #(.M_IN(M_IN), .N_LIM(N_LIM), .AW(AW)) u_offset (
        .clk       (clk),
        .rst       (rst),
        .en        (en_q),
        .lane_last (lane_last),
        .offset    (offset),
        .step      (step)
    );

    bwa_addr_stage #(.K_NCU(K_NCU), .AW(AW)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .en         (en_q),
        .finish     (step.finish),
        .lane       (lane),
        .offset     (offset),
        .base       (base_q),
        .act        (act_q),
        .rd_addr    (rd_addr),
        .addr_valid (addr_valid),
        .done       (done)
    );
endmodule

// File: rtl/bwa_addr_gen_chk.sv
module bwa_addr_gen_chk #(
    parameter int M_IN  = 3,
    parameter int N_LIM = 8,
    parameter int K_NCU = 4,
    parameter int AW    = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          addr_valid,
    input logic          done,
    input logic [AW-1:0] rd_addr,
    input logic [AW-1:0] base_q
);
    localparam int ROWS = bwa_pkg::rows_needed(M_IN, N_LIM);
    localparam int SPAN = (ROWS - 1) * (M_IN + 1) + K_NCU - 1;

    // R2: an address follows every running cycle
    a_r2_valid_after_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> addr_valid);

    // R2: no address without a running cycle before it
    a_r2_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !addr_valid);

    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: done coincides with the end of the run
    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && addr_valid));

    // R5: the run only ends with a done marker
    a_r5_end_marked: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R3: addresses stay within the layer's span
    a_r3_addr_span: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> ((rd_addr - base_q) <= AW'(SPAN)));

    // R7: a start during a run leaves the captured base untouched
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(base_q));
endmodule

bind bwa_addr_gen bwa_addr_gen_chk #(
    .M_IN(M_IN), .N_LIM(N_LIM), .K_NCU(K_NCU), .AW(AW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .addr_valid (addr_valid),
    .done       (done),
    .rd_addr    (rd_addr),
    .base_q     (base_q)
);

// File: tb/bwa_addr_gen_tb.sv
module bwa_addr_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 3;
    localparam int PM [NI] = '{3, 1, 4};
    localparam int PN [NI] = '{8, 2, 9};
    localparam int PK [NI] = '{4, 5, 3};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start [NI];
    logic [7:0] base  [NI];
    logic [7:0] act   [NI];
    logic [7:0] addr  [NI];
    logic       vld   [NI];
    logic       bsy   [NI];
    logic       dn    [NI];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar g = 0; g < NI; g++) begin : gen_dut
        bwa_addr_gen #(.M_IN(PM[g]), .N_LIM(PN[g]), .K_NCU(PK[g]), .AW(8)) u_dut (
            .clk        (clk),
            .rst        (rst),
            .start      (start[g]),
            .layer_base (base[g]),
            .active_num (act[g]),
            .rd_addr    (addr[g]),
            .addr_valid (vld[g]),
            .busy       (bsy[g]),
            .done       (dn[g])
        );
    end

    function automatic int rows_of(input int i);
        return ((PN[i] + PM[i]) / (PM[i] + 1)) + 1;
    endfunction

    function automatic int exp_addr(input int i, input int b, input int a, input int r, input int c);
        return b + r * (PM[i] + 1) + ((c < a) ? c : a);
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // One full sequence on instance i; poke issues a start mid-run (R7).
    task automatic run_seq(input int i, input int b, input int a, input bit poke);
        int rows;
        bit last;
        rows = rows_of(i);
        @(negedge clk);
        start[i] = 1'b1; base[i] = 8'(b); act[i] = 8'(a);
        @(negedge clk);
        start[i] = 1'b0; base[i] = 8'h5A; act[i] = 8'd0;   // R2: must not matter
        check("R2 busy after start", int'(bsy[i]), 1);
        check("R2 no address yet", int'(vld[i]), 0);
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < PK[i]; c++) begin
                @(negedge clk);
                last = (r == rows - 1) && (c == PK[i] - 1);
                check("R3 R4 R8 address", int'(addr[i]), exp_addr(i, b, a, r, c));
                check("R2 valid", int'(vld[i]), 1);
                check("R5 R6 done marker", int'(dn[i]), int'(last));
                check("R6 busy", int'(bsy[i]), int'(!last));
                start[i] = poke && (r == 0) && (c == 0);
                if (poke) base[i] = 8'h33;
            end
        end
        @(negedge clk);
        start[i] = 1'b0;
        check("R6 valid after end", int'(vld[i]), 0);
        check("R6 done after end", int'(dn[i]), 0);
        check("R7 R5 idle after end", int'(bsy[i]), 0);
    endtask

    initial begin
        for (int i = 0; i < NI; i++) begin
            start[i] = 1'b0; base[i] = '0; act[i] = '0;
        end
        repeat (3) @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            check("R1 reset valid", int'(vld[i]), 0);
            check("R1 reset busy", int'(bsy[i]), 0);
        end
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            check("R1 addr", int'(addr[i]), 0);
            check("R1 done", int'(dn[i]), 0);
            check("R1 idle", int'(bsy[i]), 0);
        end
        // Directed corners
        run_seq(0, 10, 4, 1'b0);   // R3 no clamp, active == K
        run_seq(0, 20, 2, 1'b0);   // R8 clamp
        run_seq(0, 0, 0, 1'b0);    // R8 active zero
        run_seq(1, 40, 5, 1'b0);   // R9 K > N
        run_seq(1, 7, 3, 1'b0);    // R9 with clamp
        run_seq(2, 50, 9, 1'b0);   // R4 stride not dividing limit
        run_seq(2, 60, 3, 1'b1);   // R7 start during run
        run_seq(0, 90, 1, 1'b1);   // R7
        // Constrained random
        void'($urandom(32'd1234));
        for (int t = 0; t < 24; t++) begin
            int i;
            i = int'($urandom % NI);
            run_seq(i, int'($urandom % 150), int'($urandom % (PK[i] + 2)), bit'($urandom % 2));
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule